// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block brings a DDR3 device from power-on to a usable state by driving a DFI-style command port on its own, then hands the port to the normal memory controller. One pulse on `start` launches a fixed programme. The block picks the PHY read and write phases, pulses the PHY reset, and releases the DRAM reset with the clock enable still low. It then raises the clock enable, loads the four mode registers for CWL 5, CL 6 and burst length 8, and issues a ZQ calibration. At the end it switches the control word to controller-select and raises `done`.

Each wait in the programme is a parameter counted in clock cycles, so a simulation can shrink the intervals. Every command sits on phase 0 for exactly one cycle, with a matching issue strobe. All other phases stay silent for the whole run.

Top module: `ddr3_init_seq`

## Requirements
- R1: After reset `ctrl`, every command bit, every issue bit, `addr`, `bank`, `phy_rst`, `done`, `rd_phase` and `wr_phase` are all zero. They stay zero until `start` is sampled high.
- R2: On the cycle after `start` is sampled high, the following happen together:
  - `rd_phase` becomes 2 and `wr_phase` becomes 3.
  - `ctrl` becomes 0x0E. The control bits are select = bit0, clock enable = bit1, termination = bit2 and active-low DRAM reset = bit3.
  - `phy_rst` goes high for `T_PHY_RST` cycles, then stays low for another `T_PHY_RST` cycles.
- R3: Next, `ctrl` is 0x0C (clock enable low) for `T_RESET` cycles. During this interval `addr` and `bank` are zero and nothing is issued.
- R4: Next, `ctrl` is 0x0E for `T_CKE` cycles before the first command. Any command issue happens only while clock enable and reset release are both high.
- R5: The four mode-register loads follow on consecutive cycles, in this order:
  - address 0x200, bank 2
  - address 0x000, bank 3
  - address 0x006, bank 1
  - address 0x920, bank 0

  Each load carries command 0x0F on phase 0. The command bits are CS = bit0, WE = bit1, CAS = bit2, RAS = bit3, write-data-valid = bit4 and read-enable = bit5.
- R6: After the last load there is an idle wait of `T_MRD` cycles. Then ZQ calibration is issued for one cycle (command 0x03, address 0x400, bank 0), followed by an idle wait of `T_ZQ` cycles.
- R7: After the final wait, `ctrl` becomes 0x01 and `done` rises. Both hold until reset.
- R8: A `start` pulse while a sequence is running, or after `done`, has no effect on any output.
- R9: Only phase 0 ever carries a command or an issue bit. Outside the five issue cycles every command bit, `addr` and `bank` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches the programme when idle |
| done | output | 1 | Programme complete, port handed over |
| phy_rst | output | 1 | PHY reset pulse |
| rd_phase | output | PHASE_W | PHY read phase select |
| wr_phase | output | PHASE_W | PHY write phase select |
| ctrl | output | 4 | Control word (select, CKE, ODT, RESET_N) |
| cmd | output | NUM_PHASES*6 | Per-phase command words, phase 0 in the low bits |
| issue | output | NUM_PHASES | Per-phase one-cycle issue strobes |
| addr | output | ADDR_W | Row address for the issued command |
| bank | output | BANK_W | Bank address for the issued command |

## Verification
The bench builds the block with short waits: 3 cycles for the PHY reset, 9 for the DRAM reset release, 4 for the clock enable, 2 after the last mode load and 5 after ZQ. With these values a complete programme lasts 31 cycles. Each run can then be compared cycle by cycle against a computed schedule, including the segment boundaries and the one-cycle PHY reset edges.

The runs use different random idle gaps before `start`. Random `start` pulses are also driven throughout each run and after `done`.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;
    localparam int CTL_W    = 4;
    localparam int CMD_W    = 6;
    localparam int CTL_SEL  = 0;
    localparam int CTL_CKE  = 1;
    localparam int CTL_ODT  = 2;
    localparam int CTL_RSTN = 3;
    localparam int CMD_CS   = 0;
    localparam int CMD_WE   = 1;
    localparam int CMD_CAS  = 2;
    localparam int CMD_RAS  = 3;

    localparam logic [CTL_W-1:0] CTL_SW   = 4'b1110;
    localparam logic [CTL_W-1:0] CTL_REL  = 4'b1100;
    localparam logic [CTL_W-1:0] CTL_HAND = 4'b0001;

    localparam logic [CMD_W-1:0] CMD_MRS = 6'b001111;
    localparam logic [CMD_W-1:0] CMD_ZQ  = 6'b000011;

    localparam int NUM_STEPS = 5;
    localparam int STEP_W    = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PHY_ON,
        ST_PHY_OFF,
        ST_REL,
        ST_CKE,
        ST_MRS,
        ST_MRD,
        ST_ZQ,
        ST_ZQW,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ddr3_init_cmdrom.sv
module ddr3_init_cmdrom
    import ddr3_init_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BANK_W = 3
) (
    input  logic [STEP_W-1:0] step,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [CMD_W-1:0]  cmd
);
    // Steps 0..3 are the mode loads (MR2, MR3, MR1, MR0); step 4 is ZQ.
    always_comb begin
        addr = '0;
        bank = '0;
        cmd  = '0;
        case (step)
            3'd0: begin addr = ADDR_W'(12'h200); bank = BANK_W'(2); cmd = CMD_MRS; end
            3'd1: begin addr = ADDR_W'(12'h000); bank = BANK_W'(3); cmd = CMD_MRS; end
            3'd2: begin addr = ADDR_W'(12'h006); bank = BANK_W'(1); cmd = CMD_MRS; end
            3'd3: begin addr = ADDR_W'(12'h920); bank = BANK_W'(0); cmd = CMD_MRS; end
            3'd4: begin addr = ADDR_W'(12'h400); bank = BANK_W'(0); cmd = CMD_ZQ;  end
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
    import ddr3_init_pkg::*;
#(
    parameter int NUM_PHASES = 4,
    parameter int ADDR_W     = 14,
    parameter int BANK_W     = 3,
    parameter int RD_PHASE   = 2,
    parameter int WR_PHASE   = 3,
    parameter int T_PHY_RST  = 1000,
    parameter int T_RESET    = 50000,
    parameter int T_CKE      = 10000,
    parameter int T_MRD      = 200,
    parameter int T_ZQ       = 200,
    localparam int PHASE_W   = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    output logic                        done,
    output logic                        phy_rst,
    output logic [PHASE_W-1:0]          rd_phase,
    output logic [PHASE_W-1:0]          wr_phase,
    output logic [CTL_W-1:0]            ctrl,
    output logic [NUM_PHASES*CMD_W-1:0] cmd,
    output logic [NUM_PHASES-1:0]       issue,
    output logic [ADDR_W-1:0]           addr,
    output logic [BANK_W-1:0]           bank
);
    localparam int MAX_A = (T_PHY_RST > T_RESET) ? T_PHY_RST : T_RESET;
    localparam int MAX_B = (T_CKE > T_MRD) ? T_CKE : T_MRD;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_T = (MAX_C > T_ZQ) ? MAX_C : T_ZQ;
    localparam int CNT_W = $clog2(MAX_T + 1);

    typedef struct packed {
        seq_state_e         st;
        logic [STEP_W-1:0]  step;
        logic [PHASE_W-1:0] rdph;
        logic [PHASE_W-1:0] wrph;
    } seq_reg_t;

    seq_reg_t           r_d, r_q;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_expired;
    logic [ADDR_W-1:0]  rom_addr;
    logic [BANK_W-1:0]  rom_bank;
    logic [CMD_W-1:0]   rom_cmd;
    logic               issue_on;

    ddr3_init_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    ddr3_init_cmdrom #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_rom (
        .step (r_q.step),
        .addr (rom_addr),
        .bank (rom_bank),
        .cmd  (rom_cmd)
    );

    // Next-state logic; every wait state lasts exactly its parameter in cycles.
    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (r_q.st)
            ST_IDLE: if (start) begin
                r_d.st   = ST_PHY_ON;
                r_d.rdph = PHASE_W'(RD_PHASE);
                r_d.wrph = PHASE_W'(WR_PHASE);
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_PHY_RST - 1);
            end
            ST_PHY_ON: if (tmr_expired) begin
                r_d.st   = ST_PHY_OFF;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_PHY_RST - 1);
            end
            ST_PHY_OFF: if (tmr_expired) begin
                r_d.st   = ST_REL;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_RESET - 1);
            end
            ST_REL: if (tmr_expired) begin
                r_d.st   = ST_CKE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_CKE - 1);
            end
            ST_CKE: if (tmr_expired) begin
                r_d.st   = ST_MRS;
                r_d.step = '0;
            end
            ST_MRS: begin
                r_d.step = r_q.step + 1'b1;
                if (r_q.step == STEP_W'(NUM_STEPS - 2)) begin
                    r_d.st   = ST_MRD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_MRD - 1);
                end
            end
            ST_MRD: if (tmr_expired) r_d.st = ST_ZQ;
            ST_ZQ: begin
                r_d.st   = ST_ZQW;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_ZQ - 1);
            end
            ST_ZQW: if (tmr_expired) r_d.st = ST_DONE;
            default: r_d.st = ST_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, step: '0, rdph: '0, wrph: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // Moore output decode from the registered state.
    assign issue_on = (r_q.st == ST_MRS) || (r_q.st == ST_ZQ);

    always_comb begin
        case (r_q.st)
            ST_IDLE: ctrl = '0;
            ST_REL:  ctrl = CTL_REL;
            ST_DONE: ctrl = CTL_HAND;
            default: ctrl = CTL_SW;
        endcase
    end

    assign phy_rst  = (r_q.st == ST_PHY_ON);
    assign done     = (r_q.st == ST_DONE);
    assign rd_phase = r_q.rdph;
    assign wr_phase = r_q.wrph;
    assign addr     = issue_on ? rom_addr : '0;
    assign bank     = issue_on ? rom_bank : '0;

    generate
        for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
            if (p == 0) begin : g_active
                assign cmd[CMD_W-1:0] = issue_on ? rom_cmd : '0;
                assign issue[0]       = issue_on;
            end else begin : g_silent
                assign cmd[p*CMD_W +: CMD_W] = '0;
                assign issue[p]              = 1'b0;
            end
        end
    endgenerate

    assert_phy_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_rst) |-> (ctrl == CTL_SW));

    assert_release_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_REL && !tmr_expired) |=> (r_q.st == ST_REL));

    assert_cmd_needs_cke_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issue[0] |-> (ctrl[CTL_CKE] && ctrl[CTL_RSTN]));

    assert_mr3_after_mr2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue[0] && bank == BANK_W'(3)) |-> ($past(issue[0]) && $past(bank) == BANK_W'(2)));

    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    assert_handover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ctrl == CTL_HAND && !phy_rst && issue == '0));
endmodule

// File: tb/ddr3_init_seq_bench.sv
module ddr3_init_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TP = 3, TR = 9, TC = 4, TM = 2, TZ = 5;
    localparam int NPH = 4;
    localparam int B0 = TP, B1 = 2*TP, B2 = B1+TR, B3 = B2+TC, B4 = B3+4;
    localparam int B5 = B4+TM, B6 = B5+1, B7 = B6+TZ;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic done, phy_rst;
    logic [1:0] rd_phase, wr_phase;
    logic [3:0] ctrl;
    logic [NPH*6-1:0] cmd;
    logic [NPH-1:0] issue;
    logic [13:0] addr;
    logic [2:0] bank;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr3_init_seq #(.NUM_PHASES(NPH), .T_PHY_RST(TP), .T_RESET(TR),
                    .T_CKE(TC), .T_MRD(TM), .T_ZQ(TZ)) u_ddr3_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .phy_rst(phy_rst),
        .rd_phase(rd_phase), .wr_phase(wr_phase), .ctrl(ctrl), .cmd(cmd),
        .issue(issue), .addr(addr), .bank(bank));

    function automatic logic [29:0] pack(logic p, logic [3:0] c, logic [5:0] k,
                                         logic i, logic [13:0] a, logic [2:0] b, logic d);
        return {p, c, k, i, a, b, d};
    endfunction

    // Expected tuple for cycle k after the start edge.
    function automatic void expect_at(input int k, output logic [29:0] v, output string tag);
        logic [13:0] a = '0;
        logic [2:0]  b = '0;
        if (k < B0)      begin v = pack(1, 4'hE, 0, 0, 0, 0, 0); tag = "R2"; end
        else if (k < B1) begin v = pack(0, 4'hE, 0, 0, 0, 0, 0); tag = "R2"; end
        else if (k < B2) begin v = pack(0, 4'hC, 0, 0, 0, 0, 0); tag = "R3"; end
        else if (k < B3) begin v = pack(0, 4'hE, 0, 0, 0, 0, 0); tag = "R4"; end
        else if (k < B4) begin
            case (k - B3)
                0: begin a = 14'h200; b = 3'd2; end
                1: begin a = 14'h000; b = 3'd3; end
                2: begin a = 14'h006; b = 3'd1; end
                default: begin a = 14'h920; b = 3'd0; end
            endcase
            v = pack(0, 4'hE, 6'h0F, 1, a, b, 0); tag = "R5";
        end
        else if (k < B5)  begin v = pack(0, 4'hE, 0, 0, 0, 0, 0); tag = "R6"; end
        else if (k == B5) begin v = pack(0, 4'hE, 6'h03, 1, 14'h400, 0, 0); tag = "R6"; end
        else if (k < B7)  begin v = pack(0, 4'hE, 0, 0, 0, 0, 0); tag = "R6"; end
        else              begin v = pack(0, 4'h1, 0, 0, 0, 0, 1); tag = "R7"; end
    endfunction

    function automatic logic [29:0] actual();
        return pack(phy_rst, ctrl, cmd[5:0], issue[0], addr, bank, done);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_one(input int idle);
        logic [29:0] ev;
        string tag;
        rst_n = 1'b0;
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < idle; i++) begin
            @(negedge clk);
            check("R1", {30'd0, actual(), rd_phase, wr_phase}, 64'd0);
            check("R1_cmd", {40'd0, cmd}, 64'd0);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < B7 + 6; k++) begin
            expect_at(k, ev, tag);
            check(tag, {34'd0, actual()}, {34'd0, ev});
            check("R2_phase", {60'd0, rd_phase, wr_phase}, {60'd0, 2'd2, 2'd3});
            check("R9", {37'd0, cmd[NPH*6-1:6], issue[NPH-1:1]}, 64'd0);
            if (k > 0 && ($urandom % 3) == 0) check("R8", 0, 0);
            start = (($urandom % 3) == 0);  // R8: ignored while busy or done
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'h5EED_0042);
        run_one(1);
        run_one(0);
        for (int r = 0; r < 5; r++) run_one(int'($urandom % 7) + 1);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule